// File: doc/BRIEF.md
# Thermometer Interval Histogram Counter

This block builds a code-density histogram for calibrating a flash converter core. While calibration mode is on, each valid sample cycle brings in a 16-bit word from the comparators that are currently selected. The block works out which decision interval the analog sample fell into and adds one to that interval's counter. The interval index is the number of ones in the word. A word that is not a clean thermometer code, because of a bubble, still maps to a legal interval.

A controller clears the counters, turns on calibration mode and pulses `start`. The block then accepts a batch of exactly 2^K samples and pulses `done`. With a uniform test signal the controller compares each count against the ideal value of N/16. It reads the counts one at a time through an index/data port that has one cycle of latency. In normal mode the block ignores everything except `clear` and reads.

Top module: `ivl_hist`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every interval reads back 0.
- R2: A counted sample increments the interval whose index equals the number of ones in `thermo`. With LEVELS=16 there are 17 intervals, 0 to 16. Index 0 is the all-zero word, which lies below every reference level. Index 16 is the all-ones word, which lies above every reference level.
- R3: A non-monotonic word with bubbles, such as 16'h0057, is counted in the interval equal to its number of ones (5 for 16'h0057). It is never counted outside 0..16.
- R4: A sample is counted only while `cal_mode` is 1, `busy` is 1 and `sample_valid` is 1. While `cal_mode` is 0, `start` is ignored. If `cal_mode` drops during a batch, the batch is abandoned: `busy` goes to 0 one cycle later and `done` is not raised.
- R5: A pulse on `start` while idle in calibration mode opens a batch of N = 2^K counted samples. In the cycle after the Nth sample is counted, `done` is 1 for exactly one cycle and `busy` is 0. Samples that arrive later are not counted.
- R6: Each counter is K+1 bits wide. It saturates at 2^(K+1)-1 and does not wrap when batches accumulate without a clear.
- R7: A `clear` pulse zeroes every counter in one cycle. It takes priority over an increment in the same cycle. It does not change the batch's sample count.
- R8: `rd_data` shows the count of interval `rd_idx` one cycle after `rd_idx` is applied. An index above LEVELS reads 0.
- R9: A `start` pulse while a batch is in progress is ignored. The batch still ends after N counted samples from its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cal_mode | input | 1 | 1 = calibration mode, 0 = normal mode (idle) |
| clear | input | 1 | Zero all interval counters |
| start | input | 1 | Open a batch of N samples |
| sample_valid | input | 1 | `thermo` holds a sample this cycle |
| thermo | input | LEVELS (16) | Comparator outputs, bit i set when the input is above level i |
| rd_idx | input | IDXW (5) | Interval index to read |
| rd_data | output | K+1 (7) | Registered count of interval `rd_idx` |
| busy | output | 1 | A batch is open |
| done | output | 1 | One-cycle pulse when a batch completes |

## Verification
The assertions assume that `cal_mode` is a level held for many cycles and that `start` and `clear` are single-cycle pulses from a controller. They also assume that `rd_idx` is held steady across a read whenever a check depends on the read value. Apart from that they do not limit the words that arrive on `thermo`. The stimulus changes every input only at the falling clock edge. It keeps `start` and `clear` to one cycle each, and it covers every interval, including the two end intervals and words full of bubbles.

// File: rtl/ivl_hist_pkg.sv
// Shared helpers for the interval histogram counter.
// Assumes LEVELS >= 1.
package ivl_hist_pkg;
    // Width of an index that can name intervals 0..levels.
    function automatic int idx_width(input int levels);
        return $clog2(levels + 1);
    endfunction
endpackage

// File: rtl/ivl_hist_index.sv
// Maps a comparator word onto its interval index by counting ones.
// Assumes nothing about the ordering of the word, so bubbles are tolerated.
module ivl_hist_index #(
    parameter int LEVELS = 16,
    parameter int IDXW   = 5
) (
    input  logic [LEVELS-1:0] word,
    output logic [IDXW-1:0]   index
);
    // Sum the set bits; the result is always within 0..LEVELS.
    always_comb begin
        index = '0;
        for (int b = 0; b < LEVELS; b++) begin
            index = index + IDXW'(word[b]);
        end
    end
endmodule

// File: rtl/ivl_hist_batch.sv
// Batch sequencer: opens a batch on start, counts accepted samples,
// closes after 2**K of them with a one-cycle done pulse.
// Assumes start is a pulse; leaving calibration mode abandons the batch.
module ivl_hist_batch #(
    parameter int K = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_mode,
    input  logic start,
    input  logic sample_valid,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam logic [K-1:0] LAST = '1;

    logic [K-1:0] seen_q;

    assign accept = busy && cal_mode && sample_valid;

    // Track the open batch, the number of samples taken and the end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            seen_q <= '0;
        end else if (!cal_mode) begin
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                seen_q <= '0;
            end else if (accept) begin
                seen_q <= seen_q + 1'b1;
                if (seen_q == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ivl_hist_bins.sv
// Bank of saturating interval counters with a registered read port.
// Assumes clear has priority over an increment; out-of-range reads give 0.
module ivl_hist_bins #(
    parameter int NBINS = 17,
    parameter int IDXW  = 5,
    parameter int CW    = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            inc,
    input  logic [IDXW-1:0] inc_idx,
    input  logic [IDXW-1:0] rd_idx,
    output logic [CW-1:0]   rd_data
);
    localparam logic [CW-1:0] TOP = '1;

    logic [NBINS*CW-1:0] flat;

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        logic [CW-1:0] c_q;
        // One counter per interval, stuck at its ceiling once reached.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                c_q <= '0;
            end else if (inc && inc_idx == IDXW'(g) && c_q != TOP) begin
                c_q <= c_q + 1'b1;
            end
        end
        assign flat[g*CW +: CW] = c_q;
    end

    // Registered read of the selected interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (int'(rd_idx) < NBINS) begin
            rd_data <= flat[int'(rd_idx)*CW +: CW];
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/ivl_hist.sv
// Interval histogram counter top: index decode, batch control, counter bank.
// Assumes the controller drives cal_mode as a level and start/clear as pulses.
module ivl_hist #(
    parameter int LEVELS = 16,
    parameter int K      = 6,
    localparam int IDXW  = ivl_hist_pkg::idx_width(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_mode,
    input  logic              clear,
    input  logic              start,
    input  logic              sample_valid,
    input  logic [LEVELS-1:0] thermo,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [K:0]        rd_data,
    output logic              busy,
    output logic              done
);
    localparam int NBINS = LEVELS + 1;
    localparam int CW    = K + 1;

    logic [IDXW-1:0] sample_idx;
    logic            accept;

    ivl_hist_index #(.LEVELS(LEVELS), .IDXW(IDXW)) u_index (
        .word  (thermo),
        .index (sample_idx)
    );

    ivl_hist_batch #(.K(K)) u_batch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_mode     (cal_mode),
        .start        (start),
        .sample_valid (sample_valid),
        .accept       (accept),
        .busy         (busy),
        .done         (done)
    );

    ivl_hist_bins #(.NBINS(NBINS), .IDXW(IDXW), .CW(CW)) u_bins (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .inc     (accept),
        .inc_idx (sample_idx),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/ivl_hist_chk.sv
// Protocol checker for ivl_hist, attached by bind.
// Assumes start and clear are pulses and cal_mode is a level.
module ivl_hist_chk #(
    parameter int DW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cal_mode,
    input logic          clear,
    input logic          start,
    input logic [DW-1:0] rd_data,
    input logic          busy,
    input logic          done
);
    assert_idle_in_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_mode |=> !busy);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_end_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || !$past(cal_mode)));

    assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ##1 (rd_data == '0));
endmodule

bind ivl_hist ivl_hist_chk #(.DW(K + 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_mode (cal_mode),
    .clear    (clear),
    .start    (start),
    .rd_data  (rd_data),
    .busy     (busy),
    .done     (done)
);

// File: tb/ivl_hist_bench.sv
// Directed bench for ivl_hist: one task per scenario, each checking itself.
module ivl_hist_bench;
    localparam int LEVELS = 16;
    localparam int K      = 6;
    localparam int N      = 1 << K;
    localparam int NB     = LEVELS + 1;
    localparam int SAT    = (1 << (K + 1)) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cal_mode = 1'b0;
    logic              clear = 1'b0;
    logic              start = 1'b0;
    logic              sample_valid = 1'b0;
    logic [LEVELS-1:0] thermo = '0;
    logic [4:0]        rd_idx = '0;
    logic [K:0]        rd_data;
    logic              busy;
    logic              done;

    int n_chk = 0;
    int n_bad = 0;
    int exp_bin [NB];

    always #4 clk = ~clk;

    ivl_hist #(.LEVELS(LEVELS), .K(K)) u_ivl_hist (
        .clk (clk), .rst_n (rst_n), .cal_mode (cal_mode), .clear (clear),
        .start (start), .sample_valid (sample_valid), .thermo (thermo),
        .rd_idx (rd_idx), .rd_data (rd_data), .busy (busy), .done (done)
    );

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int ones(input logic [LEVELS-1:0] w);
        int s = 0;
        for (int b = 0; b < LEVELS; b++) s += int'(w[b]);
        return s;
    endfunction

    function automatic logic [LEVELS-1:0] level_word(input int k);
        return (k == 0) ? '0 : LEVELS'(16'hFFFF >> (LEVELS - k));
    endfunction

    task automatic feed(input logic [LEVELS-1:0] w, output bit d);
        thermo = w;
        sample_valid = 1'b1;
        @(negedge clk);
        d = done;
        sample_valid = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int i = 0; i < NB; i++) exp_bin[i] = 0;
    endtask

    task automatic read_bin(input int i, output int v);
        rd_idx = 5'(i);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic check_bins(input string req);
        int v;
        for (int i = 0; i < NB; i++) begin
            read_bin(i, v);
            chk(req, v, exp_bin[i]);
        end
    endtask

    // R1: state straight after reset
    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        check_bins("R1 bins");
    endtask

    // R2 R5: clean levels over all intervals, done timing, no count after
    task automatic t_sweep();
        bit d;
        cal_mode = 1'b1;
        do_clear();
        pulse_start();
        chk("R5 busy open", int'(busy), 1);
        for (int i = 0; i < N; i++) begin
            feed(level_word(i % NB), d);
            exp_bin[i % NB]++;
            chk("R5 done timing", int'(d), (i == N - 1) ? 1 : 0);
        end
        chk("R5 busy closed", int'(busy), 0);
        feed(level_word(3), d);
        chk("R5 done once", int'(d), 0);
        check_bins("R2 R5 bins");
    endtask

    // R3: bubbly words land on their ones count
    task automatic t_bubble();
        bit d;
        logic [LEVELS-1:0] w;
        do_clear();
        pulse_start();
        feed(16'h0057, d);
        exp_bin[5]++;
        for (int i = 1; i < N; i++) begin
            w = LEVELS'(i * 40503) ^ LEVELS'(i << 5);
            feed(w, d);
            exp_bin[ones(w)]++;
        end
        chk("R3 done", int'(d), 1);
        check_bins("R3 bins");
    endtask

    // R4: normal mode ignores start and samples; abort on leaving calibration
    task automatic t_normal();
        bit d;
        int v;
        do_clear();
        cal_mode = 1'b0;
        pulse_start();
        chk("R4 no start", int'(busy), 0);
        feed(level_word(2), d);
        read_bin(2, v);
        chk("R4 normal ignored", v, 0);
        cal_mode = 1'b1;
        pulse_start();
        for (int i = 0; i < 5; i++) feed(level_word(3), d);
        cal_mode = 1'b0;
        @(negedge clk);
        chk("R4 abort busy", int'(busy), 0);
        for (int i = 0; i < 3; i++) begin
            feed(level_word(3), d);
            chk("R4 abort no done", int'(d), 0);
        end
        cal_mode = 1'b1;
        read_bin(3, v);
        chk("R4 abort count", v, 5);
    endtask

    // R9: start during a batch does not restart it
    task automatic t_restart();
        bit d;
        do_clear();
        pulse_start();
        for (int i = 0; i < 10; i++) feed(level_word(7), d);
        pulse_start();
        for (int i = 10; i < N; i++) begin
            feed(level_word(7), d);
            chk("R9 end point", int'(d), (i == N - 1) ? 1 : 0);
        end
        exp_bin[7] = N;
        check_bins("R9 bins");
    endtask

    // R6: two full batches into one interval saturate
    task automatic t_saturate();
        bit d;
        int v;
        do_clear();
        for (int b = 0; b < 2; b++) begin
            pulse_start();
            for (int i = 0; i < N; i++) feed(level_word(16), d);
        end
        read_bin(16, v);
        chk("R6 saturated", v, SAT);
        read_bin(0, v);
        chk("R6 other bin", v, 0);
    endtask

    // R7: clear wins over a same-cycle increment, batch count unaffected
    task automatic t_clear();
        bit d;
        int v;
        do_clear();
        pulse_start();
        for (int i = 0; i < 3; i++) feed(level_word(16), d);
        clear = 1'b1;
        feed(level_word(0), d);
        clear = 1'b0;
        for (int i = 0; i < NB; i++) exp_bin[i] = 0;
        read_bin(16, v);
        chk("R7 cleared", v, 0);
        for (int i = 4; i < N; i++) begin
            feed(level_word(8), d);
            chk("R7 batch length", int'(d), (i == N - 1) ? 1 : 0);
        end
        exp_bin[8] = N - 4;
        check_bins("R7 bins");
    endtask

    // R8: out-of-range indices and read latency
    task automatic t_read();
        int v;
        read_bin(17, v);
        chk("R8 idx 17", v, 0);
        read_bin(31, v);
        chk("R8 idx 31", v, 0);
        rd_idx = 5'd8;
        @(posedge clk);
        #1;
        chk("R8 latency", int'(rd_data), N - 4);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) exp_bin[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_bubble();
        t_normal();
        t_restart();
        t_saturate();
        t_clear();
        t_read();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule